// File: doc/BRIEF.md
# Audio Effect Mode Qualifier and Decoder

This block sits between the slow, board-level mode-select pins of an audio effect processor and the processing core. It watches four static control lines: a bass/field select, two gain-select lines and an active-low filter-off line. It samples them once per audio frame, on each rising edge of the LR (word) clock. A line's new level is taken only after it has been seen in two consecutive frame samples, so short bounces on the pins are thrown away. From the settled levels it decodes enable flags for bass boost, stereo widening, bypass and the band-limit filter, together with a 3-bit gain code.

Two of the lines, the bass/field select and the filter-off line, alter the character of the processing. Switching them abruptly would cause an audible click. A settled change on either of them is therefore not applied at once. The block raises a one-cycle change request and holds the active settings until the external mute sequencer, once it has ramped the output down, pulses `apply_i`. The gain-select lines act directly once settled.

A small state machine controls the hand-off. In state IDLE, the transition "detect" moves it to PEND when the settled bass/field select or filter-off level differs from the active one; on that transition the change request is raised. In state PEND, the transition "commit" moves it back to IDLE when `apply_i` is high, copying the latest settled levels into the active settings. In IDLE an `apply_i` pulse has no effect.

Top module: `fx_mode_qual`

## Requirements
- R1: After reset, `bypass_o` is 1, `bass_en_o`, `widen_en_o`, `band_flt_o` and `chg_req_o` are 0, and `gain_code_o` is 0. Every control line is taken as HIGH after reset.
- R2: A control line is sampled once per frame, at the rising edge of `lr_clk_i`. A new level is accepted only when it is seen in 2 consecutive frame samples. A level that lasts one frame changes no output and raises no request.
- R3: `flt_off_i` is active low: once applied, LOW gives `band_flt_o`=1 and HIGH gives `band_flt_o`=0.
- R4: When both settled gain-select lines are HIGH, `bypass_o`=1, `bass_en_o`=0, `widen_en_o`=0 and `gain_code_o`=0.
- R5: With the active bass/field select LOW, the pair (`gsel1_i`,`gsel2_i`) decodes as follows: LL gives bass and widening with code 4; LH gives widening only with code 0; HL gives bass and widening with code 1.
- R6: With the active bass/field select HIGH, widening is off and the pair decodes as follows: LL gives bass with code 3; LH gives bass with code 4; HL gives bass with code 2. Gain codes are 0 = 0 dB, 1 = +4 dB, 2 = +6 dB, 3 = +10 dB, 4 = +13 dB.
- R7: `chg_req_o` is a one-cycle pulse, raised on the detect transition when the settled bass/field select or filter-off level differs from the active one. A change on a gain-select line raises no request.
- R8: The active bass/field select and filter-off levels change only on the commit transition (`apply_i` high in PEND), and they take the latest settled levels. An `apply_i` pulse in IDLE has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lr_clk_i | input | 1 | Asynchronous LR (frame) clock; its rising edge marks a frame |
| fld_sel_i | input | 1 | Bass/field select (LOW: bass plus widening table, HIGH: bass-only table) |
| gsel1_i | input | 1 | Gain select line 1 |
| gsel2_i | input | 1 | Gain select line 2 |
| flt_off_i | input | 1 | Band-limit filter off when HIGH, on when LOW |
| apply_i | input | 1 | Commit pulse from the mute sequencer |
| chg_req_o | output | 1 | One-cycle request for a mute-and-apply sequence |
| bass_en_o | output | 1 | Bass boost enable |
| widen_en_o | output | 1 | Stereo widening enable |
| bypass_o | output | 1 | Bass and widening bypassed |
| band_flt_o | output | 1 | Band-limit filter enable |
| gain_code_o | output | 3 | Maximum bass gain code |

## Verification
The hardest case to reach is the exact boundary of qualification. The stimulus must include a pulse one frame long, which is sampled once and must be dropped, and a hold of two or more frames, which must be taken. The bench keeps the LR clock on a fixed 16-cycle frame and changes inputs for a whole number of frames, so a pulse of one frame always covers exactly one sample point.

A second hard case is a change that is settled while a request is still pending. To reach it, the bench changes both the bass/field select and the filter-off line before sending the commit. It then checks that only one request was raised and that the commit took both new levels.

// File: rtl/fx_mode_pkg.sv
package fx_mode_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_PEND
    } mode_st_e;

    localparam logic [2:0] GAIN_0DB  = 3'd0;
    localparam logic [2:0] GAIN_4DB  = 3'd1;
    localparam logic [2:0] GAIN_6DB  = 3'd2;
    localparam logic [2:0] GAIN_10DB = 3'd3;
    localparam logic [2:0] GAIN_13DB = 3'd4;

    typedef struct packed {
        logic       bass;
        logic       widen;
        logic       bypass;
        logic [2:0] gain;
    } fx_cfg_t;

endpackage

// File: rtl/fx_sync2.sv
module fx_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/fx_frame_tick.sv
module fx_frame_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic lr_i,
    output logic tick_o
);
    logic lr_s;
    logic lr_d_q;

    fx_sync2 #(.W(1), .RST_VAL(1'b0)) u_lr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (lr_i),
        .q_o   (lr_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lr_d_q <= 1'b0;
        else        lr_d_q <= lr_s;
    end

    assign tick_o = lr_s & ~lr_d_q;
endmodule

// File: rtl/fx_level_qual.sv
module fx_level_qual #(
    parameter int           W           = 4,
    parameter int           QUAL_FRAMES = 2,
    parameter logic [W-1:0] RST_VAL     = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] qual_o
);
    localparam int RUN_W = $clog2(QUAL_FRAMES + 1);
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(QUAL_FRAMES);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic             prev_q;
        logic             qual_q;
        logic [RUN_W-1:0] run_q;
        logic [RUN_W-1:0] run_nx;

        always_comb begin
            if (lvl_i[i] != prev_q)  run_nx = RUN_W'(1);
            else if (run_q >= RUN_LIM) run_nx = run_q;
            else                     run_nx = run_q + 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= RST_VAL[i];
                qual_q <= RST_VAL[i];
                run_q  <= '0;
            end else if (tick_i) begin
                prev_q <= lvl_i[i];
                run_q  <= run_nx;
                if ((lvl_i[i] != qual_q) && (run_nx >= RUN_LIM))
                    qual_q <= lvl_i[i];
            end
        end

        assign qual_o[i] = qual_q;
    end
endmodule

// File: rtl/fx_mode_qual.sv
module fx_mode_qual
    import fx_mode_pkg::*;
#(
    parameter int QUAL_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lr_clk_i,
    input  logic       fld_sel_i,
    input  logic       gsel1_i,
    input  logic       gsel2_i,
    input  logic       flt_off_i,
    input  logic       apply_i,
    output logic       chg_req_o,
    output logic       bass_en_o,
    output logic       widen_en_o,
    output logic       bypass_o,
    output logic       band_flt_o,
    output logic [2:0] gain_code_o
);
    localparam int NLINE = 4;
    localparam int B_FLD = 3;
    localparam int B_G1  = 2;
    localparam int B_G2  = 1;
    localparam int B_FLT = 0;

    logic [NLINE-1:0] raw_lines;
    logic [NLINE-1:0] sync_lines;
    logic [NLINE-1:0] qual_lines;
    logic             tick;

    assign raw_lines = {fld_sel_i, gsel1_i, gsel2_i, flt_off_i};

    fx_sync2 #(.W(NLINE), .RST_VAL({NLINE{1'b1}})) u_in_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_lines),
        .q_o   (sync_lines)
    );

    fx_frame_tick u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .lr_i   (lr_clk_i),
        .tick_o (tick)
    );

    fx_level_qual #(
        .W           (NLINE),
        .QUAL_FRAMES (QUAL_FRAMES),
        .RST_VAL     ({NLINE{1'b1}})
    ) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .lvl_i  (sync_lines),
        .qual_o (qual_lines)
    );

    mode_st_e st_q, st_nx;
    logic     act_fld_q, act_flt_q, req_q;
    logic     differs;

    assign differs = (qual_lines[B_FLD] != act_fld_q) ||
                     (qual_lines[B_FLT] != act_flt_q);

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: if (differs) st_nx = ST_PEND;
            ST_PEND: if (apply_i) st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q     <= 1'b0;
            act_fld_q <= 1'b1;
            act_flt_q <= 1'b1;
        end else begin
            req_q <= (st_q == ST_IDLE) && differs;
            if ((st_q == ST_PEND) && apply_i) begin
                act_fld_q <= qual_lines[B_FLD];
                act_flt_q <= qual_lines[B_FLT];
            end
        end
    end

    fx_cfg_t cfg;

    always_comb begin
        cfg        = '0;
        cfg.bypass = qual_lines[B_G1] & qual_lines[B_G2];
        unique case ({act_fld_q, qual_lines[B_G1], qual_lines[B_G2]})
            3'b000: begin cfg.bass = 1'b1; cfg.widen = 1'b1; cfg.gain = GAIN_13DB; end
            3'b001: begin cfg.widen = 1'b1; cfg.gain = GAIN_0DB; end
            3'b010: begin cfg.bass = 1'b1; cfg.widen = 1'b1; cfg.gain = GAIN_4DB; end
            3'b100: begin cfg.bass = 1'b1; cfg.gain = GAIN_10DB; end
            3'b101: begin cfg.bass = 1'b1; cfg.gain = GAIN_13DB; end
            3'b110: begin cfg.bass = 1'b1; cfg.gain = GAIN_6DB; end
            default: cfg.gain = GAIN_0DB;
        endcase
    end

    assign chg_req_o   = req_q;
    assign bass_en_o   = cfg.bass;
    assign widen_en_o  = cfg.widen;
    assign bypass_o    = cfg.bypass;
    assign gain_code_o = cfg.gain;
    assign band_flt_o  = ~act_flt_q;
endmodule

// File: rtl/fx_mode_qual_chk.sv
module fx_mode_qual_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       apply_i,
    input logic       chg_req_o,
    input logic       bass_en_o,
    input logic       widen_en_o,
    input logic       bypass_o,
    input logic       band_flt_o,
    input logic [2:0] gain_code_o
);
    // R7
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_req_o |=> !chg_req_o);

    // R4
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_o |-> (!bass_en_o && !widen_en_o && gain_code_o == 3'd0));

    // R5
    widen_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (widen_en_o && !bass_en_o) |-> gain_code_o == 3'd0);

    // R6
    bass_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bass_en_o |-> (gain_code_o != 3'd0 && gain_code_o <= 3'd4));

    // R8
    filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(apply_i) |-> $stable(band_flt_o));
endmodule

bind fx_mode_qual fx_mode_qual_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .apply_i     (apply_i),
    .chg_req_o   (chg_req_o),
    .bass_en_o   (bass_en_o),
    .widen_en_o  (widen_en_o),
    .bypass_o    (bypass_o),
    .band_flt_o  (band_flt_o),
    .gain_code_o (gain_code_o)
);

// File: tb/fx_mode_qual_bench.sv
module fx_mode_qual_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_FRAME = 8;
    localparam int FRAME      = 2 * HALF_FRAME;
    localparam int WD_CYCLES  = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lr = 1'b0;
    logic fld = 1'b1, g1 = 1'b1, g2 = 1'b1, fltn = 1'b1, apply = 1'b0;
    logic chg_req, bass_en, widen_en, bypass, band_flt;
    logic [2:0] gain;

    int n_cmp = 0, n_bad = 0, req_cnt = 0;
    bit done = 1'b0;
    bit run_cmp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fx_mode_qual u_fx_mode_qual (
        .clk (clk), .rst_n (rst_n), .lr_clk_i (lr),
        .fld_sel_i (fld), .gsel1_i (g1), .gsel2_i (g2), .flt_off_i (fltn),
        .apply_i (apply), .chg_req_o (chg_req), .bass_en_o (bass_en),
        .widen_en_o (widen_en), .bypass_o (bypass), .band_flt_o (band_flt),
        .gain_code_o (gain)
    );

    // behavioural reference: delay queues, per-line sample history, pending flag
    logic [3:0] in_q [$];
    logic       lr_q [$];
    int         m_run [4];
    logic [3:0] m_prev, m_qual;
    logic       m_afld, m_aflt, m_wait, m_req;

    function automatic logic [5:0] exp_cfg(input logic f, input logic a, input logic b);
        logic [2:0] gc;
        logic bs, wd;
        bs = 0; wd = 0; gc = 0;
        if (!(a && b)) begin
            if (!f) begin
                wd = 1;
                if (!a && !b) begin bs = 1; gc = 4; end
                else if (a)   begin bs = 1; gc = 1; end
            end else begin
                bs = 1;
                if (!a && !b) gc = 3;
                else if (!a)  gc = 4;
                else          gc = 2;
            end
        end
        return {bs, wd, a && b, gc};
    endfunction

    task automatic model_reset();
        in_q = '{4'hF, 4'hF};
        lr_q = '{1'b0, 1'b0, 1'b0};
        for (int i = 0; i < 4; i++) m_run[i] = 0;
        m_prev = 4'hF; m_qual = 4'hF;
        m_afld = 1; m_aflt = 1; m_wait = 0; m_req = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            logic [3:0] samp;
            logic       tk;
            logic [3:0] q_old;
            samp  = in_q[0];
            tk    = lr_q[1] && !lr_q[0];
            q_old = m_qual;
            m_req = !m_wait && ((q_old[3] != m_afld) || (q_old[0] != m_aflt));
            if (!m_wait) begin
                if (m_req) m_wait = 1;
            end else if (apply) begin
                m_afld = q_old[3]; m_aflt = q_old[0]; m_wait = 0;
            end
            if (tk) begin
                for (int i = 0; i < 4; i++) begin
                    if (samp[i] != m_prev[i]) m_run[i] = 1;
                    else if (m_run[i] < 2) m_run[i]++;
                    m_prev[i] = samp[i];
                    if (samp[i] != m_qual[i] && m_run[i] >= 2) m_qual[i] = samp[i];
                end
            end
            void'(in_q.pop_front());
            in_q.push_back({fld, g1, g2, fltn});
            void'(lr_q.pop_front());
            lr_q.push_back(lr);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the reference every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            logic [5:0] e;
            e = exp_cfg(m_afld, m_qual[2], m_qual[1]);
            chk(m_afld ? "R6 bass" : "R5 bass", bass_en, e[5]);
            chk(m_afld ? "R6 widen" : "R5 widen", widen_en, e[4]);
            chk("R4 bypass", bypass, e[3]);
            chk(m_afld ? "R6 gain" : "R5 gain", gain, e[2:0]);
            chk("R3 band filter", band_flt, !m_aflt);
            chk("R7 request", chg_req, m_req);
            if (chg_req) req_cnt++;
        end
    end

    task automatic frames(input int n);
        repeat (n * FRAME) @(negedge clk);
    endtask

    task automatic pulse_apply();
        @(negedge clk); apply = 1'b1;
        @(negedge clk); apply = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_cfg(input string tag, input logic [5:0] e);
        chk(tag, {bass_en, widen_en, bypass, gain}, e);
    endtask

    initial begin
        forever begin
            repeat (HALF_FRAME) @(negedge clk);
            lr = ~lr;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 bypass", bypass, 1);
        chk("R1 enables", {bass_en, widen_en, band_flt, chg_req}, 0);
        chk("R1 gain", gain, 0);
        run_cmp = 1'b1;

        // R6 bass-only table, gain lines need no request
        g1 = 0; g2 = 0; frames(4); chk_cfg("R6 LL", {1'b1, 1'b0, 1'b0, 3'd3});
        g1 = 0; g2 = 1; frames(4); chk_cfg("R6 LH", {1'b1, 1'b0, 1'b0, 3'd4});
        g1 = 1; g2 = 0; frames(4); chk_cfg("R6 HL", {1'b1, 1'b0, 1'b0, 3'd2});
        g1 = 1; g2 = 1; frames(4); chk_cfg("R4 HH", {1'b0, 1'b0, 1'b1, 3'd0});
        chk("R7 no request on gain change", req_cnt, 0);

        // R2 one-frame glitches dropped
        fld = 0; g1 = 0; frames(1); fld = 1; g1 = 1; frames(4);
        chk("R2 glitch request", req_cnt, 0);
        chk("R2 glitch bypass kept", bypass, 1);

        // R8 held until commit, then R5 table
        g1 = 0; g2 = 0; frames(4);
        fld = 0; frames(4);
        chk("R7 one request", req_cnt, 1);
        chk_cfg("R8 held before commit", {1'b1, 1'b0, 1'b0, 3'd3});
        pulse_apply();
        chk_cfg("R5 LL", {1'b1, 1'b1, 1'b0, 3'd4});
        g1 = 0; g2 = 1; frames(4); chk_cfg("R5 LH", {1'b0, 1'b1, 1'b0, 3'd0});
        g1 = 1; g2 = 0; frames(4); chk_cfg("R5 HL", {1'b1, 1'b1, 1'b0, 3'd1});

        // R8 commit in IDLE ignored
        pulse_apply();
        chk_cfg("R8 idle commit ignored", {1'b1, 1'b1, 1'b0, 3'd1});
        chk("R8 idle commit no request", req_cnt, 1);

        // R3 filter, active low
        fltn = 0; frames(4);
        chk("R7 filter request", req_cnt, 2);
        chk("R8 filter held", band_flt, 0);
        pulse_apply();
        chk("R3 filter on", band_flt, 1);

        // R8 two changes while pending, one commit takes both
        fld = 1; frames(4);
        chk("R7 request while pending", req_cnt, 3);
        fltn = 1; frames(4);
        chk("R7 no second request", req_cnt, 3);
        pulse_apply();
        chk("R3 filter off", band_flt, 0);
        chk_cfg("R8 latest levels", {1'b1, 1'b0, 1'b0, 3'd2});
        frames(2);
        chk("R7 settled after commit", req_cnt, 3);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule